// File: doc/BRIEF.md
# Shift-and-Operate Datapath with Condition Flags

This block is the data-processing step of a 32-bit integer pipeline. Each transaction carries two operands, an operation code, a shift kind with an amount, the current condition-flag word and a flag-update request. The second operand first passes through a barrel shifter. The shifted value then goes either to an adder/subtractor or to a bitwise unit, together with the first operand. The block returns the result, a result-write enable and the next value of the four condition flags: negative, zero, carry and overflow.

Transactions enter on a valid/ready handshake and leave from a single output register on a second valid/ready handshake. A transaction is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer with no loss and no duplication. The flag word uses bit 3 for N, bit 2 for Z, bit 1 for C and bit 0 for V.

Top module: `shalu_top`

## Requirements
- R1: An input is accepted on a rising edge with `in_valid` and `in_ready` both high. `in_ready` equals `!out_valid || out_ready`. An accepted input appears one cycle later with `out_valid` high. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R2: Opcodes 0 to 5 give A+B, A+B+C, A-B, A-B-!C, B-A and B-A-!C, where B is the shifted operand and C is the incoming carry.
- R3: Opcodes 6 to 11 give A&B, A|B, A^B, A&~B, B and ~B.
- R4: Opcodes 12 to 15 (A-B, A+B, A&B, A^B) always drive `out_wr_en` low and always update the flags, whatever `in_setflags` is. Every other opcode drives `out_wr_en` high.
- R5: Shift kinds are 0 for logical left, 1 for logical right, 2 for arithmetic left, 3 for arithmetic right, 4 for rotate right and 5 for rotate through carry. Kind 2 behaves exactly like kind 0. Logical shifts fill the vacated bits with zeros, and the last bit shifted out becomes the shifter carry.
- R6: An arithmetic right shift fills the vacated bits with copies of bit 31.
- R7: A rotate right by n moves bit n-1 into bit 31 and into the shifter carry. Kind 5 ignores the amount: the incoming C enters bit 31, and the old bit 0 becomes the shifter carry.
- R8: A shift amount of 0 with kinds 0 to 4, and any amount with kinds 6 and 7, leaves the operand and the carry unchanged.
- R9: When the flags are updated, N equals bit 31 of the result and Z is set exactly when the result is zero.
- R10: For additions C is the carry out of bit 31. For subtractions C is set when no borrow occurs. V is set on signed overflow.
- R11: For the bitwise opcodes C takes the shifter carry and V keeps its incoming value.
- R12: When `in_setflags` is low and the opcode is not a compare, `out_flags` equals `in_flags`.
- R13: During and after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Block can take a transaction |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand, before shifting |
| in_op | input | 4 | Operation code |
| in_shkind | input | 3 | Shift kind |
| in_shamt | input | 5 | Shift amount |
| in_flags | input | 4 | Current flags {N,Z,C,V} |
| in_setflags | input | 1 | Request a flag update |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Computed value |
| out_wr_en | output | 1 | Result is to be written back |
| out_flags | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the block with its default 32-bit width, so the 5-bit amount covers every shift from 0 to 31. This reaches the single-bit and 31-bit edges, the wrap of a rotate, and carry extraction from both ends of the word. A behavioural reference computes each expected result with wide signed and unsigned integer arithmetic and shift operators. It models the output register cycle by cycle while the consumer stalls at random, so held outputs and overflow cases at the signed limits are covered.

// File: rtl/shalu_pkg.sv
package shalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_RSB = 4'd4,  OP_RSC = 4'd5,  OP_AND = 4'd6,  OP_ORR = 4'd7,
    OP_EOR = 4'd8,  OP_BIC = 4'd9,  OP_MOV = 4'd10, OP_MVN = 4'd11,
    OP_CMP = 4'd12, OP_CMN = 4'd13, OP_TST = 4'd14, OP_TEQ = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0, SK_LSR = 3'd1, SK_ASL = 3'd2, SK_ASR = 3'd3,
    SK_ROR = 3'd4, SK_RRX = 3'd5, SK_RS6 = 3'd6, SK_RS7 = 3'd7
  } shift_kind_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b11;
  endfunction

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op <= 4'd5) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

endpackage

// File: rtl/shalu_shifter.sv
module shalu_shifter #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  dout,
  output logic          cout
);
  import shalu_pkg::*;

  logic          is_left;
  logic [AW-1:0] rot_amt;
  logic [AW-1:0] left_idx;
  logic [AW-1:0] right_idx;
  logic [W-1:0]  keep_low;
  logic [W-1:0]  keep_high;
  logic [W-1:0]  stage [AW+1];

  assign is_left   = (kind == SK_LSL) || (kind == SK_ASL);
  assign left_idx  = AW'(W - int'(amt));
  assign right_idx = amt - AW'(1);
  assign rot_amt   = is_left ? left_idx : amt;
  assign keep_low  = {W{1'b1}} >> amt;
  assign keep_high = {W{1'b1}} << amt;

  // log2(W) rotate-right stages, each by a power of two
  assign stage[0] = din;
  for (genvar k = 0; k < AW; k++) begin : g_rot
    localparam int STEP = 2 ** k;
    assign stage[k+1] = rot_amt[k] ? {stage[k][STEP-1:0], stage[k][W-1:STEP]}
                                   : stage[k];
  end

  always_comb begin
    dout = din;
    cout = cin;
    if (kind == SK_RRX) begin
      dout = {cin, din[W-1:1]};
      cout = din[0];
    end else if (amt != '0) begin
      unique case (kind)
        SK_LSL, SK_ASL: begin
          dout = stage[AW] & keep_high;
          cout = din[left_idx];
        end
        SK_LSR: begin
          dout = stage[AW] & keep_low;
          cout = din[right_idx];
        end
        SK_ASR: begin
          dout = (stage[AW] & keep_low) | ({W{din[W-1]}} & ~keep_low);
          cout = din[right_idx];
        end
        SK_ROR: begin
          dout = stage[AW];
          cout = din[right_idx];
        end
        default: begin
          dout = din;
          cout = cin;
        end
      endcase
    end
  end

endmodule

// File: rtl/shalu_addsub.sv
module shalu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  import shalu_pkg::*;

  logic [W-1:0] x;
  logic [W-1:0] y;
  logic         ci;
  logic [W:0]   wide;

  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    unique case (op)
      OP_ADD, OP_CMN: begin x = a; y = b;  ci = 1'b0; end
      OP_ADC:         begin x = a; y = b;  ci = cin;  end
      OP_SUB, OP_CMP: begin x = a; y = ~b; ci = 1'b1; end
      OP_SBC:         begin x = a; y = ~b; ci = cin;  end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
      OP_RSC:         begin x = b; y = ~a; ci = cin;  end
      default:        begin x = a; y = b;  ci = 1'b0; end
    endcase
  end

  assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

endmodule

// File: rtl/shalu_logic.sv
module shalu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] res
);
  import shalu_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = a & b;
      OP_ORR:         res = a | b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_BIC:         res = a & ~b;
      OP_MOV:         res = b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/shalu_top.sv
module shalu_top #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [3:0]    in_op,
  input  logic [2:0]    in_shkind,
  input  logic [AW-1:0] in_shamt,
  input  logic [3:0]    in_flags,
  input  logic          in_setflags,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_result,
  output logic          out_wr_en,
  output logic [3:0]    out_flags
);
  import shalu_pkg::*;

  logic [W-1:0] sh_val;
  logic         sh_c;
  logic [W-1:0] add_val;
  logic         add_c;
  logic         add_v;
  logic [W-1:0] lg_val;
  logic         arith;
  logic         cmp;
  logic         upd;
  logic [W-1:0] res_n;
  logic [3:0]   flags_n;
  logic         c_n;
  logic         v_n;
  logic         take;
  logic         upd_q;

  shalu_shifter #(.W(W), .AW(AW)) u_shift (
    .din (in_b),
    .kind(in_shkind),
    .amt (in_shamt),
    .cin (in_flags[FLG_C]),
    .dout(sh_val),
    .cout(sh_c)
  );

  shalu_addsub #(.W(W)) u_add (
    .a   (in_a),
    .b   (sh_val),
    .op  (in_op),
    .cin (in_flags[FLG_C]),
    .sum (add_val),
    .cout(add_c),
    .ovf (add_v)
  );

  shalu_logic #(.W(W)) u_logic (
    .a  (in_a),
    .b  (sh_val),
    .op (in_op),
    .res(lg_val)
  );

  assign arith = op_is_arith(in_op);
  assign cmp   = op_is_compare(in_op);
  assign upd   = in_setflags || cmp;
  assign res_n = arith ? add_val : lg_val;
  assign c_n   = arith ? add_c : sh_c;
  assign v_n   = arith ? add_v : in_flags[FLG_V];

  always_comb begin
    flags_n = in_flags;
    if (upd) begin
      flags_n[FLG_N] = res_n[W-1];
      flags_n[FLG_Z] = (res_n == '0);
      flags_n[FLG_C] = c_n;
      flags_n[FLG_V] = v_n;
    end
  end

  // single output register with pass-through ready
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr_en  <= 1'b0;
      out_flags  <= '0;
      upd_q      <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= res_n;
      out_wr_en  <= !cmp;
      out_flags  <= flags_n;
      upd_q      <= upd;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_flags) && $stable(out_wr_en)); // R1

  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_is_compare(in_op) |=> out_valid && !out_wr_en); // R4

  AST_ZERO_AMOUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_shamt == '0 && in_shkind != SK_RRX |->
      sh_val == in_b && sh_c == in_flags[FLG_C]); // R8

  AST_RRX_THROUGH_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_shkind == SK_RRX |->
      sh_c == in_b[0] && sh_val[W-1] == in_flags[FLG_C]); // R7

  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == OP_SUB |-> add_c == (in_a >= sh_val)); // R10

  AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && upd_q |-> out_flags[FLG_N] == out_result[W-1] &&
      out_flags[FLG_Z] == (out_result == '0)); // R9

endmodule

// File: tb/shalu_top_tb_top.sv
module shalu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [3:0]  in_op = '0;
  logic [2:0]  in_shkind = '0;
  logic [4:0]  in_shamt = '0;
  logic [3:0]  in_flags = '0;
  logic        in_setflags = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic [3:0]  out_flags;

  int total = 0;
  int bad = 0;

  logic        m_valid = 1'b0;
  logic [31:0] m_res = '0;
  logic        m_wr = 1'b0;
  logic [3:0]  m_flags = '0;
  string       m_tag = "R13";

  always #2 clk = ~clk;

  shalu_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_shkind(in_shkind),
    .in_shamt(in_shamt), .in_flags(in_flags), .in_setflags(in_setflags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_flags(out_flags)
  );

  // behavioural reference for one transaction
  task automatic ref_calc(input logic [31:0] a, input logic [31:0] b,
                          input int op, input int kind, input int n,
                          input logic [3:0] fl, input logic se,
                          output logic [31:0] r, output logic wr,
                          output logic [3:0] fo);
    logic [31:0] v;
    logic        sc;
    longint      ua, ub, sa, sb, u, s, cy;
    logic        cmp, ar, cf, vf;
    v  = b;
    sc = fl[1];
    if (kind == 5) begin
      v  = {fl[1], b[31:1]};
      sc = b[0];
    end else if (n != 0) begin
      case (kind)
        0, 2: begin v = b << n; sc = b[32-n]; end
        1:    begin v = b >> n; sc = b[n-1]; end
        3:    begin v = $unsigned($signed(b) >>> n); sc = b[n-1]; end
        4:    begin v = (b >> n) | (b << (32 - n)); sc = b[n-1]; end
        default: ;
      endcase
    end
    cy  = longint'(fl[1]);
    ua  = longint'({32'd0, a});
    ub  = longint'({32'd0, v});
    sa  = longint'($signed(a));
    sb  = longint'($signed(v));
    cmp = (op >= 12);
    ar  = (op <= 5) || op == 12 || op == 13;
    u = 0; s = 0;
    case (op)
      0, 13: begin u = ua + ub;           s = sa + sb;           end
      1:     begin u = ua + ub + cy;      s = sa + sb + cy;      end
      2, 12: begin u = ua - ub;           s = sa - sb;           end
      3:     begin u = ua - ub - (1 - cy); s = sa - sb - (1 - cy); end
      4:     begin u = ub - ua;           s = sb - sa;           end
      5:     begin u = ub - ua - (1 - cy); s = sb - sa - (1 - cy); end
      default: ;
    endcase
    case (op)
      6, 14:  r = a & v;
      7:      r = a | v;
      8, 15:  r = a ^ v;
      9:      r = a & ~v;
      10:     r = v;
      11:     r = ~v;
      default: r = u[31:0];
    endcase
    if (op <= 1 || op == 13) cf = (u > 64'sh0FFFFFFFF);
    else if (ar)             cf = (u >= 0);
    else                     cf = sc;
    vf = ar ? (s > 64'sh7FFFFFFF || s < -64'sh80000000) : fl[0];
    wr = !cmp;
    fo = (se || cmp) ? {r[31], r == 32'd0, cf, vf} : fl;
  endtask

  task automatic check_out();
    total++;
    if (out_valid !== m_valid ||
        (m_valid && (out_result !== m_res || out_wr_en !== m_wr ||
                     out_flags !== m_flags))) begin
      bad++;
      $display("FAIL %s: got v=%0b r=%h w=%0b f=%b exp v=%0b r=%h w=%0b f=%b",
               m_tag, out_valid, out_result, out_wr_en, out_flags,
               m_valid, m_res, m_wr, m_flags);
    end
  endtask

  // one cycle: drive at negedge, predict the register, compare at next negedge
  task automatic step(input logic [31:0] a, input logic [31:0] b, input int op,
                      input int kind, input int n, input logic [3:0] fl,
                      input logic se, input logic iv, input logic rdy,
                      input string tag);
    logic        exp_rdy;
    logic [31:0] r;
    logic        w;
    logic [3:0]  f;
    in_a = a; in_b = b; in_op = 4'(op); in_shkind = 3'(kind);
    in_shamt = 5'(n); in_flags = fl; in_setflags = se;
    in_valid = iv; out_ready = rdy;
    #1;
    exp_rdy = !m_valid || rdy;
    total++;
    if (in_ready !== exp_rdy) begin
      bad++;
      $display("FAIL R1: in_ready got %0b exp %0b", in_ready, exp_rdy);
    end
    ref_calc(a, b, op, kind, n, fl, se, r, w, f);
    @(negedge clk);
    if (iv && exp_rdy) begin
      m_valid = 1'b1; m_res = r; m_wr = w; m_flags = f; m_tag = tag;
    end else if (rdy) begin
      m_valid = 1'b0;
    end
    check_out();
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, got hung exp done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R13: out_valid=%0b in_ready=%0b exp 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_out();

    step(32'h7FFFFFFF, 32'h1, 0, 0, 0, 4'b0000, 1, 1, 1, "R10");
    step(32'h5, 32'h5, 2, 0, 0, 4'b0000, 1, 1, 1, "R9");
    step(32'h3, 32'h5, 2, 0, 0, 4'b0010, 1, 1, 1, "R10");
    step(32'hFFFFFFFF, 32'h1, 1, 0, 0, 4'b0010, 1, 1, 1, "R2");
    step(32'h10, 32'h3, 3, 0, 0, 4'b0000, 1, 1, 1, "R2");
    step(32'h10, 32'h3, 4, 0, 0, 4'b0000, 1, 1, 1, "R2");
    step(32'h10, 32'h30, 5, 0, 0, 4'b0000, 1, 1, 1, "R2");
    step(32'hF0F0FFFF, 32'h0000FF00, 9, 0, 0, 4'b0000, 1, 1, 1, "R3");
    step(32'h0, 32'h12345678, 11, 0, 0, 4'b0000, 1, 1, 1, "R3");
    step(32'hAAAA5555, 32'hFFFF0000, 8, 0, 0, 4'b0000, 1, 1, 1, "R3");
    step(32'h9, 32'h9, 12, 0, 0, 4'b0001, 0, 1, 1, "R4");
    step(32'h1, 32'h1, 15, 0, 0, 4'b0000, 0, 1, 1, "R4");
    step(32'h0, 32'h80000000, 10, 1, 4, 4'b0000, 1, 1, 1, "R5");
    step(32'hFFFFFFFF, 32'h80000001, 6, 0, 1, 4'b0001, 1, 1, 1, "R11");
    step(32'hFFFFFFFF, 32'h80000001, 6, 2, 1, 4'b0001, 1, 1, 1, "R5");
    step(32'h0, 32'h80000000, 10, 3, 31, 4'b0000, 1, 1, 1, "R6");
    step(32'h0, 32'h123456F8, 10, 4, 8, 4'b0000, 1, 1, 1, "R7");
    step(32'h0, 32'h00000003, 10, 5, 9, 4'b0010, 1, 1, 1, "R7");
    step(32'h0, 32'h80000001, 10, 1, 0, 4'b0011, 1, 1, 1, "R8");
    step(32'h0, 32'h80000001, 10, 6, 7, 4'b0011, 1, 1, 1, "R8");
    step(32'h0, 32'h0, 10, 0, 0, 4'b1010, 0, 1, 1, "R12");
    // R1: stall the consumer with input waiting
    step(32'h11, 32'h22, 0, 0, 0, 4'b0000, 1, 1, 0, "R1");
    step(32'h33, 32'h44, 0, 0, 0, 4'b0000, 1, 1, 0, "R1");
    step(32'h33, 32'h44, 0, 0, 0, 4'b0000, 1, 1, 0, "R1");
    step(32'h55, 32'h66, 7, 0, 0, 4'b0000, 1, 1, 1, "R1");
    step(32'h0, 32'h0, 0, 0, 0, 4'b0000, 0, 0, 1, "R1");

    for (int i = 0; i < 3000; i++) begin
      int    op;
      string tg;
      op = $urandom_range(0, 15);
      tg = (op >= 12) ? "R4" : (op <= 5) ? "R2" : "R3";
      step($urandom, $urandom, op, $urandom_range(0, 7), $urandom_range(0, 31),
           4'($urandom), 1'($urandom), ($urandom_range(0, 9) < 8),
           ($urandom_range(0, 9) < 7), tg);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule